// File: doc/BRIEF.md
# Supervisory Reset and Watchdog Controller

This block produces the reset for a processor from three independent causes. The first is an undervoltage flag from an external comparator. The second is an active-low manual reset line, such as a push-button. The third is a watchdog that expects the software to keep toggling a strobe line. While any cause is present, the reset is held. When the last cause goes away, the reset stays asserted for a further fixed stretch before it releases. The block drives the reset as a complementary pair of outputs: one active-low and one active-high.

The undervoltage flag also works as the block's own asynchronous initialisation. While it is set, every register is forced to its reset state and the outputs assert at once. The manual reset line and the strobe lines pass through a synchronizer first. The manual reset is then filtered, so that it must stay low for a number of consecutive cycles before it counts. The watchdog counter restarts on either edge of the strobe. It is held at zero for the whole time the reset is asserted, and it is ignored entirely while the companion drive flag reports that the strobe is not being driven. Every period is a parameter in clock cycles.

Top module: `supv_reset_ctrl`

## Requirements
- R1: While `uv_flag_i` is high, both outputs show reset immediately, without waiting for a clock edge. After `uv_flag_i` falls, reset stays asserted for exactly `STRETCH_CYC` rising edges and deasserts on edge number `STRETCH_CYC`.
- R2: The manual reset counts only after `FILT_CYC` consecutive sampled-low cycles. A low pulse that lasts fewer sampled cycles has no effect on the outputs.
- R3: After an accepted manual reset is released, reset deasserts `STRETCH_CYC + SYNC_STAGES + 1` edges after the first edge that samples `mrst_n_i` high.
- R4: With the strobe driven but never toggled, the watchdog expires `WD_CYC` cycles after reset deasserts. Each expiry gives a reset pulse of exactly `STRETCH_CYC` cycles, and the pattern then repeats.
- R5: Both rising and falling strobe edges restart the watchdog. If the strobe toggles at an interval of `WD_CYC` cycles or less, no reset is ever produced. An interval of `WD_CYC + 1` cycles produces a reset.
- R6: While `wd_drive_i` is low, the watchdog never asserts reset, whatever the strobe does.
- R7: The watchdog is held cleared for as long as reset is asserted, from any cause. After any release, the first watchdog expiry therefore comes exactly `WD_CYC` cycles later.
- R8: A cause that asserts during the stretch keeps reset asserted. The stretch then restarts from the release of that cause.
- R9: `sys_rst_n_o` is always the exact complement of `sys_rst_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| uv_flag_i | input | 1 | Undervoltage flag, active high. Also resets the block asynchronously. |
| mrst_n_i | input | 1 | Manual reset request, active low, asynchronous |
| wd_strobe_i | input | 1 | Watchdog strobe; either edge services the watchdog |
| wd_drive_i | input | 1 | High when the strobe line is actively driven; low disables the watchdog |
| sys_rst_n_o | output | 1 | Reset output, active low |
| sys_rst_o | output | 1 | Reset output, active high |

## Verification
The bench builds the block with `STRETCH_CYC = 12`, `WD_CYC = 20`, `FILT_CYC = 4` and two synchronizer stages. Periods this small make it cheap to sweep every manual-reset pulse length around the filter threshold. They also allow every strobe toggle interval from 1 to `WD_CYC + 1`, so the watchdog boundary is hit from both sides. Stretch lengths are measured cycle by cycle for each cause, including a restart in the middle of a stretch.

// File: rtl/supv_pkg.sv
package supv_pkg;

  // Bits needed to hold a counter that reaches lim (at least one bit)
  function automatic int unsigned cnt_width(int unsigned lim);
    if (lim < 1) return 1;
    return $clog2(lim + 1);
  endfunction

  // Edges from manual release sample to reset deassertion
  function automatic int unsigned mr_release_edges(int unsigned stretch,
                                                   int unsigned stages);
    return stretch + stages + 1;
  endfunction

  typedef struct packed {
    logic mrst_n;
    logic strobe;
    logic drive;
  } supv_pins_t;

  localparam supv_pins_t PINS_IDLE = '{mrst_n: 1'b1, strobe: 1'b0, drive: 1'b0};

endpackage

// File: rtl/supv_sync.sv
module supv_sync #(
  parameter int unsigned             W       = 1,
  parameter int unsigned             STAGES  = 2,
  parameter logic        [W-1:0]     RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         arst_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [STAGES-1:0][W-1:0] stage_q;

  always_ff @(posedge clk_i or posedge arst_i) begin
    if (arst_i) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/supv_mr_filter.sv
module supv_mr_filter #(
  parameter int unsigned FILT_CYC = 4
) (
  input  logic clk_i,
  input  logic arst_i,
  input  logic mr_s_i,
  output logic act_o
);

  localparam int unsigned CW = supv_pkg::cnt_width(FILT_CYC);
  localparam logic [CW-1:0] FULL = CW'(FILT_CYC);

  logic [CW-1:0] low_q;

  always_ff @(posedge clk_i or posedge arst_i) begin
    if (arst_i)           low_q <= '0;
    else if (mr_s_i)      low_q <= '0;
    else if (low_q != FULL) low_q <= low_q + 1'b1;
  end

  assign act_o = (low_q == FULL);

  // R2: acceptance only follows a sampled-low cycle
  a_r2_needs_low_run: assert property (@(posedge clk_i) disable iff (arst_i)
    $rose(act_o) |-> $past(!mr_s_i));

  // R2: a high sample withdraws acceptance on the next cycle
  a_r2_release_clears: assert property (@(posedge clk_i) disable iff (arst_i)
    mr_s_i |=> !act_o);

endmodule

// File: rtl/supv_wdog.sv
module supv_wdog #(
  parameter int unsigned WD_CYC = 20
) (
  input  logic clk_i,
  input  logic arst_i,
  input  logic strobe_s_i,
  input  logic drive_s_i,
  input  logic hold_i,
  output logic edge_o,
  output logic expire_o
);

  localparam int unsigned CW = supv_pkg::cnt_width(WD_CYC - 1);
  localparam logic [CW-1:0] LAST = CW'(WD_CYC - 1);

  logic          strobe_prev_q;
  logic [CW-1:0] wcnt_q;

  assign edge_o   = strobe_s_i ^ strobe_prev_q;
  assign expire_o = drive_s_i & ~hold_i & ~edge_o & (wcnt_q == LAST);

  always_ff @(posedge clk_i or posedge arst_i) begin
    if (arst_i) begin
      strobe_prev_q <= 1'b0;
      wcnt_q        <= '0;
    end else begin
      strobe_prev_q <= strobe_s_i;
      if (hold_i || !drive_s_i || edge_o || expire_o) wcnt_q <= '0;
      else                                            wcnt_q <= wcnt_q + 1'b1;
    end
  end

  // R4: counter never passes the expiry value
  a_r4_count_bound: assert property (@(posedge clk_i) disable iff (arst_i)
    wcnt_q <= LAST);

  // R5: any strobe edge restarts the count
  a_r5_edge_clears: assert property (@(posedge clk_i) disable iff (arst_i)
    edge_o |=> (wcnt_q == '0));

  // R7: counter held at zero while reset is asserted
  a_r7_held_in_reset: assert property (@(posedge clk_i) disable iff (arst_i)
    hold_i |=> (wcnt_q == '0));

endmodule

// File: rtl/supv_stretch.sv
module supv_stretch #(
  parameter int unsigned STRETCH_CYC = 12
) (
  input  logic clk_i,
  input  logic arst_i,
  input  logic src_i,
  output logic rst_o,
  output logic rst_n_o
);

  localparam int unsigned CW = supv_pkg::cnt_width(STRETCH_CYC - 1);
  localparam logic [CW-1:0] LAST = CW'(STRETCH_CYC - 1);

  logic          rst_q;
  logic          rst_n_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or posedge arst_i) begin
    if (arst_i) begin
      rst_q   <= 1'b1;
      rst_n_q <= 1'b0;
      cnt_q   <= '0;
    end else if (src_i) begin
      rst_q   <= 1'b1;
      rst_n_q <= 1'b0;
      cnt_q   <= '0;
    end else if (rst_q) begin
      if (cnt_q == LAST) begin
        rst_q   <= 1'b0;
        rst_n_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign rst_o   = rst_q;
  assign rst_n_o = rst_n_q;

  // R3: an active cause asserts reset on the next cycle
  a_r3_source_asserts: assert property (@(posedge clk_i) disable iff (arst_i)
    src_i |=> (rst_q && !rst_n_q));

  // R8: no release before the stretch count completes
  a_r8_hold_until_done: assert property (@(posedge clk_i) disable iff (arst_i)
    (rst_q && !src_i && (cnt_q != LAST)) |=> rst_q);

endmodule

// File: rtl/supv_reset_ctrl.sv
module supv_reset_ctrl #(
  parameter int unsigned STRETCH_CYC = 200000,
  parameter int unsigned WD_CYC      = 1600000,
  parameter int unsigned FILT_CYC    = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic uv_flag_i,
  input  logic mrst_n_i,
  input  logic wd_strobe_i,
  input  logic wd_drive_i,
  output logic sys_rst_n_o,
  output logic sys_rst_o
);

  import supv_pkg::*;

  supv_pins_t pins_raw;
  supv_pins_t pins_s;
  logic       mr_act;
  logic       wd_edge;
  logic       wd_expire;
  logic       rst_src;

  assign pins_raw = '{mrst_n: mrst_n_i, strobe: wd_strobe_i, drive: wd_drive_i};

  supv_sync #(
    .W       ($bits(supv_pins_t)),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (PINS_IDLE)
  ) u_sync (
    .clk_i  (clk_i),
    .arst_i (uv_flag_i),
    .d_i    (pins_raw),
    .q_o    (pins_s)
  );

  supv_mr_filter #(.FILT_CYC(FILT_CYC)) u_mr_filter (
    .clk_i  (clk_i),
    .arst_i (uv_flag_i),
    .mr_s_i (pins_s.mrst_n),
    .act_o  (mr_act)
  );

  supv_wdog #(.WD_CYC(WD_CYC)) u_wdog (
    .clk_i      (clk_i),
    .arst_i     (uv_flag_i),
    .strobe_s_i (pins_s.strobe),
    .drive_s_i  (pins_s.drive),
    .hold_i     (sys_rst_o),
    .edge_o     (wd_edge),
    .expire_o   (wd_expire)
  );

  assign rst_src = mr_act | wd_expire;

  supv_stretch #(.STRETCH_CYC(STRETCH_CYC)) u_stretch (
    .clk_i   (clk_i),
    .arst_i  (uv_flag_i),
    .src_i   (rst_src),
    .rst_o   (sys_rst_o),
    .rst_n_o (sys_rst_n_o)
  );

  // R9: outputs always complementary
  a_r9_complement: assert property (@(posedge clk_i) disable iff (uv_flag_i)
    sys_rst_o != sys_rst_n_o);

  // R6: an undriven strobe never produces an expiry
  a_r6_undriven_quiet: assert property (@(posedge clk_i) disable iff (uv_flag_i)
    !pins_s.drive |-> !wd_expire);

  // R7: no expiry while reset is held
  a_r7_no_expiry_in_reset: assert property (@(posedge clk_i) disable iff (uv_flag_i)
    sys_rst_o |-> !wd_expire);

endmodule

// File: tb/supv_reset_ctrl_tb.sv
module supv_reset_ctrl_tb;

  localparam int unsigned STRETCH = 12;
  localparam int unsigned WD      = 20;
  localparam int unsigned FILT    = 4;
  localparam int unsigned SYNC    = 2;
  localparam int unsigned MR_EXP  = STRETCH + SYNC + 1;

  logic clk = 1'b0;
  logic uv, mr_n, strobe, drive;
  logic rst_n, rst;
  int   n_run = 0;
  int   n_fail = 0;
  int   comp_fail = 0;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  supv_reset_ctrl #(
    .STRETCH_CYC (STRETCH),
    .WD_CYC      (WD),
    .FILT_CYC    (FILT),
    .SYNC_STAGES (SYNC)
  ) u_dut (
    .clk_i       (clk),
    .uv_flag_i   (uv),
    .mrst_n_i    (mr_n),
    .wd_strobe_i (strobe),
    .wd_drive_i  (drive),
    .sys_rst_n_o (rst_n),
    .sys_rst_o   (rst)
  );

  // R9 monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n !== ~rst) begin
      comp_fail++;
      $display("FAIL R9 complement: actual rst=%0b rst_n=%0b expected rst_n=%0b", rst, rst_n, ~rst);
    end
  end

  task automatic check_eq(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic measure_high(output int n);
    n = 0;
    while (rst === 1'b1 && n < 2000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic measure_low(output int n);
    n = 0;
    while (rst === 1'b0 && n < 2000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int n;
    uv = 1'b1; mr_n = 1'b1; strobe = 1'b0; drive = 1'b0;
    repeat (3) @(negedge clk);
    check_eq("R1 reset state rst", int'(rst), 1);
    check_eq("R1 reset state rst_n", int'(rst_n), 0);

    // R1: stretch after undervoltage release
    uv = 1'b0;
    measure_high(n);
    check_eq("R1 stretch after uv", n, STRETCH);
    repeat (4) @(negedge clk);
    uv = 1'b1;
    #1;
    check_eq("R1 asynchronous assert", int'(rst), 1);
    @(negedge clk);
    uv = 1'b0;
    measure_high(n);
    check_eq("R1 second stretch", n, STRETCH);

    // R2: filter sweep around the threshold
    for (int len = 1; len <= int'(FILT) + 2; len++) begin
      bit seen;
      repeat (5) @(negedge clk);
      mr_n = 1'b0;
      repeat (len) @(negedge clk);
      mr_n = 1'b1;
      seen = 1'b0;
      repeat (STRETCH + FILT + 10) begin
        if (rst) seen = 1'b1;
        @(negedge clk);
      end
      check_eq($sformatf("R2 pulse len %0d", len), int'(seen), int'(len >= int'(FILT)));
      measure_high(n);
    end

    // R3: stretch after manual release
    @(negedge clk);
    mr_n = 1'b0;
    repeat (FILT + 6) @(negedge clk);
    mr_n = 1'b1;
    measure_high(n);
    check_eq("R3 manual stretch", n, MR_EXP);

    // R8: new cause during the stretch restarts it
    @(negedge clk);
    uv = 1'b1;
    @(negedge clk);
    uv = 1'b0;
    repeat (5) @(negedge clk);
    mr_n = 1'b0;
    repeat (FILT + 2) @(negedge clk);
    mr_n = 1'b1;
    measure_high(n);
    check_eq("R8 restart from last release", n, MR_EXP);

    // R6: undriven strobe, idle and slowly toggling
    begin
      bit seen = 1'b0;
      repeat (3 * WD + STRETCH) begin
        if (rst) seen = 1'b1;
        @(negedge clk);
      end
      check_eq("R6 undriven idle", int'(seen), 0);
      seen = 1'b0;
      for (int c = 0; c < int'(4 * (WD + 5)); c++) begin
        if (rst) seen = 1'b1;
        if (c % int'(WD + 5) == 0) strobe = ~strobe;
        @(negedge clk);
      end
      check_eq("R6 undriven slow toggles", int'(seen), 0);
    end

    // R4: driven but stuck strobe gives periodic resets
    drive = 1'b1;
    uv = 1'b1;
    @(negedge clk);
    uv = 1'b0;
    measure_high(n);
    check_eq("R4 initial stretch", n, STRETCH);
    measure_low(n);
    check_eq("R4 first expiry interval", n, WD);
    measure_high(n);
    check_eq("R4 expiry pulse width", n, STRETCH);
    measure_low(n);
    check_eq("R4 second expiry interval", n, WD);

    // R7: long manual reset keeps the watchdog cleared
    mr_n = 1'b0;
    repeat (3 * WD) @(negedge clk);
    mr_n = 1'b1;
    measure_high(n);
    check_eq("R7 manual stretch with watchdog", n, MR_EXP);
    measure_low(n);
    check_eq("R7 full interval after release", n, WD);

    // R5: toggle interval sweep, both edges service the watchdog
    for (int k = 1; k <= int'(WD) + 1; k++) begin
      bit went_low, fired;
      int phase;
      @(negedge clk);
      uv = 1'b1;
      strobe = 1'b0;
      phase = 0;
      @(negedge clk);
      uv = 1'b0;
      went_low = 1'b0;
      fired = 1'b0;
      repeat (STRETCH + 4 * (WD + 1) + 10) begin
        if (!rst) went_low = 1'b1;
        if (went_low && rst) fired = 1'b1;
        phase++;
        if (phase == k) begin
          strobe = ~strobe;
          phase = 0;
        end
        @(negedge clk);
      end
      check_eq($sformatf("R5 toggle interval %0d", k), int'(fired), int'(k > int'(WD)));
    end

    check_eq("R9 complement at every sample", comp_fail, 0);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule